// File: doc/BRIEF.md
# Midrange Window Chip-Select Decoder

This block turns a 20-bit memory address into four active-low chip selects that share one movable window of memory. Software places the window with a control register, which holds the upper base-address bits plus a ready-mode bit and a two-bit wait count. A second, auxiliary register sets the window size. The window is cut into four equal quarters in rising address order, and each quarter drives one select. The block stays silent after reset until both registers have been written. It also reports a configuration that is not allowed, and it does not decode while such a configuration is in place.

The address is captured on the clock edge where the early address strobe is high. The selects then go low only while the later multiplexed address/data phase input is high, which is half a cycle after early-address selects. Each select is also gated by a pin-mode bit, so a pin set up as general-purpose I/O never sees a select. The ready mode and wait count are handed to the bus controller along with every access that lands in the window.

Top module: `mcs_decoder`

## Requirements
- R1: After reset, all four `cs_n` outputs are high, and `acc_hit`, `acc_rdy_mode`, `acc_wait` and `cfg_err` are all 0.
- R2: No select asserts and `acc_hit` stays 0 until `cfg_wr_ctl` and `cfg_wr_aux` have each been pulsed at least once since reset. Writing only one of the two registers leaves the window disabled.
- R3: The base-address bits A19..A13 are held in `cfg_wdata[15:9]` of a control write, and base bits A12..A0 are zero. An access hits the window when address bits above the window-size boundary equal the same bits of the base.
- R4: A size code N is held in `cfg_wdata[2:0]` of an auxiliary write. Codes 0 to 6 select a window of 8 KiB shifted left by N. Code 7 is invalid: it raises `cfg_err` and blocks every select.
- R5: For size code N, the quarter index is address bits [12+N:11+N]. Quarter i drives `cs_n[i]` low, with quarter 0 at the lowest addresses.
- R6: At most one `cs_n` bit is low at any time.
- R7: The address is captured on the rising clock edge where `addr_strobe` is 1, and it is held until the next such edge. `cs_n` is low only while `ad_phase` is 1.
- R8: A base with any bit set below the window-size boundary raises `cfg_err` and blocks all selects. A 512 KiB window (code 6) is valid only at base 0.
- R9: A base of 0 while `lower_en` is 1 raises `cfg_err` and blocks all selects.
- R10: `cs_n[i]` can be low only when `pin_cs_mode[i]` is 1. `acc_hit` does not depend on `pin_cs_mode`.
- R11: The ready-mode bit is held in control bit 2 and the wait count in control bits 1:0. `acc_rdy_mode` and `acc_wait` present these values while `acc_hit` is 1, and are 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the write-tracking flags and the captured access |
| cfg_wr_ctl | input | 1 | Write strobe for the control register (base, ready mode, wait count) |
| cfg_wr_aux | input | 1 | Write strobe for the auxiliary size register |
| cfg_wdata | input | 16 | Register write data |
| lower_en | input | 1 | The lower-memory select region is enabled, so base 0 is reserved |
| pin_cs_mode | input | 4 | Per pin: 1 means the pin works as a chip select, 0 means general-purpose I/O |
| bus_addr | input | 20 | Memory address |
| addr_strobe | input | 1 | Early address valid; the address is captured on this edge |
| ad_phase | input | 1 | The multiplexed address/data phase is active |
| cs_n | output | 4 | Active-low chip selects, one per window quarter |
| acc_hit | output | 1 | The captured access lies in the window |
| acc_rdy_mode | output | 1 | Ready mode for the captured access |
| acc_wait | output | 2 | Wait-state count for the captured access |
| cfg_err | output | 1 | The programmed configuration is not allowed |

## Verification
The checker tests the following on every cycle:
- At most one select is low.
- Every select is high outside the address/data phase and on pins in I/O mode.
- No select asserts and no hit is reported before both registers have been written; the checker tracks the register writes itself.
- No select asserts while `cfg_err` is 1.
- The captured access stays unchanged between strobes.
- The access attributes are zero whenever there is no hit.

Only the bench scenarios can show the following:
- Which quarter a given address selects for each size code.
- That misaligned bases, the base-0 overlap and the invalid size code are caught.
- That the ready mode and wait count match what was written.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

    // Attributes handed to the bus controller with each window access.
    typedef struct packed {
        logic       rdy_mode;
        logic [1:0] wait_cnt;
    } mcs_attr_t;

    // Field positions in the control word that the bus controller relies on.
    localparam int unsigned RDY_BIT  = 2;
    localparam int unsigned WAIT_MSB = 1;

endpackage

// File: rtl/mcs_cfg_regs.sv
module mcs_cfg_regs
    import mcs_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned BASE_W = 7,
    parameter int unsigned CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctl,
    input  logic              wr_aux,
    input  logic [DATA_W-1:0] wdata,
    output logic [BASE_W-1:0] base,
    output logic [CODE_W-1:0] code,
    output mcs_attr_t         attr,
    output logic              cfg_valid
);

    localparam int unsigned BASE_LO = DATA_W - BASE_W;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [CODE_W-1:0] code;
        mcs_attr_t         attr;
        logic              ctl_seen;
        logic              aux_seen;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_ctl) begin
            r_d.base          = wdata[DATA_W-1:BASE_LO];
            r_d.attr.rdy_mode = wdata[RDY_BIT];
            r_d.attr.wait_cnt = wdata[WAIT_MSB:0];
            r_d.ctl_seen      = 1'b1;
        end
        if (wr_aux) begin
            r_d.code     = wdata[CODE_W-1:0];
            r_d.aux_seen = 1'b1;
        end
    end

    // Register contents are left undefined by reset; only the write tracking clears.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.ctl_seen <= 1'b0;
            r_q.aux_seen <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign base      = r_q.base;
    assign code      = r_q.code;
    assign attr      = r_q.attr;
    assign cfg_valid = r_q.ctl_seen & r_q.aux_seen;

endmodule

// File: rtl/mcs_window_match.sv
module mcs_window_match #(
    parameter int unsigned ADDR_W   = 20,
    parameter int unsigned BASE_LSB = 13,
    parameter int unsigned NUM_CS   = 4,
    parameter int unsigned CODE_W   = 3,
    parameter int unsigned MAX_CODE = 6
) (
    input  logic [ADDR_W-1:0]          addr,
    input  logic [ADDR_W-BASE_LSB-1:0] base,
    input  logic [CODE_W-1:0]          code,
    input  logic                       lower_en,
    output logic                       hit,
    output logic [$clog2(NUM_CS)-1:0]  idx,
    output logic                       misconfig
);

    localparam int unsigned BASE_W = ADDR_W - BASE_LSB;
    localparam int unsigned SUB_W  = $clog2(NUM_CS);
    localparam int unsigned IDX_LO = BASE_LSB - SUB_W;

    logic [BASE_W:0]     span;
    logic [BASE_W-1:0]   low_mask;
    logic [ADDR_W-1:0]   shifted;
    logic                bad_code;
    logic                bad_align;
    logic                bad_full;
    logic                bad_overlap;

    always_comb begin
        span        = (BASE_W+1)'(1) << code;
        low_mask    = BASE_W'(span - 1'b1);
        bad_code    = (code > CODE_W'(MAX_CODE));
        bad_align   = |(base & low_mask);
        bad_full    = (code == CODE_W'(MAX_CODE)) && (base != '0);
        bad_overlap = (base == '0) && lower_en;
        misconfig   = bad_code | bad_align | bad_full | bad_overlap;

        hit     = (((addr[ADDR_W-1:BASE_LSB] ^ base) & ~low_mask) == '0);
        shifted = addr >> (IDX_LO + 32'(code));
        idx     = shifted[SUB_W-1:0];
    end

endmodule

// File: rtl/mcs_decoder.sv
module mcs_decoder
    import mcs_pkg::*;
#(
    parameter int unsigned ADDR_W   = 20,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned BASE_LSB = 13,
    parameter int unsigned NUM_CS   = 4,
    parameter int unsigned CODE_W   = 3,
    parameter int unsigned MAX_CODE = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_ctl,
    input  logic              cfg_wr_aux,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              lower_en,
    input  logic [NUM_CS-1:0] pin_cs_mode,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              addr_strobe,
    input  logic              ad_phase,
    output logic [NUM_CS-1:0] cs_n,
    output logic              acc_hit,
    output logic              acc_rdy_mode,
    output logic [1:0]        acc_wait,
    output logic              cfg_err
);

    localparam int unsigned BASE_W = ADDR_W - BASE_LSB;
    localparam int unsigned SUB_W  = $clog2(NUM_CS);

    logic [BASE_W-1:0] base;
    logic [CODE_W-1:0] code;
    mcs_attr_t         attr;
    logic              cfg_valid;
    logic              win_hit;
    logic [SUB_W-1:0]  win_idx;
    logic              misconfig;
    logic              cs_live;

    mcs_cfg_regs #(
        .DATA_W (DATA_W),
        .BASE_W (BASE_W),
        .CODE_W (CODE_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctl    (cfg_wr_ctl),
        .wr_aux    (cfg_wr_aux),
        .wdata     (cfg_wdata),
        .base      (base),
        .code      (code),
        .attr      (attr),
        .cfg_valid (cfg_valid)
    );

    mcs_window_match #(
        .ADDR_W   (ADDR_W),
        .BASE_LSB (BASE_LSB),
        .NUM_CS   (NUM_CS),
        .CODE_W   (CODE_W),
        .MAX_CODE (MAX_CODE)
    ) u_match (
        .addr      (bus_addr),
        .base      (base),
        .code      (code),
        .lower_en  (lower_en),
        .hit       (win_hit),
        .idx       (win_idx),
        .misconfig (misconfig)
    );

    typedef struct packed {
        logic             hit;
        logic [SUB_W-1:0] idx;
        mcs_attr_t        attr;
    } acc_t;

    acc_t acc_d, acc_q;

    assign cs_live = cfg_valid & ~misconfig;

    always_comb begin
        acc_d = acc_q;
        if (addr_strobe) begin
            acc_d.hit  = cs_live & win_hit;
            acc_d.idx  = win_idx;
            acc_d.attr = attr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    // Selects follow the later multiplexed phase, one decoder leg per pin.
    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign cs_n[g] = ~(acc_q.hit && (acc_q.idx == SUB_W'(g)) && ad_phase
                           && pin_cs_mode[g] && cs_live);
    end

    assign acc_hit      = acc_q.hit;
    assign acc_rdy_mode = acc_q.hit & acc_q.attr.rdy_mode;
    assign acc_wait     = acc_q.hit ? acc_q.attr.wait_cnt : 2'b00;
    assign cfg_err      = cfg_valid & misconfig;

endmodule

// File: rtl/mcs_decoder_chk.sv
module mcs_decoder_chk #(
    parameter int unsigned NUM_CS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr_ctl,
    input logic              cfg_wr_aux,
    input logic [NUM_CS-1:0] pin_cs_mode,
    input logic              addr_strobe,
    input logic              ad_phase,
    input logic [NUM_CS-1:0] cs_n,
    input logic              acc_hit,
    input logic              acc_rdy_mode,
    input logic [1:0]        acc_wait,
    input logic              cfg_err
);

    logic seen_ctl, seen_aux;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_ctl <= 1'b0;
            seen_aux <= 1'b0;
        end else begin
            seen_ctl <= seen_ctl | cfg_wr_ctl;
            seen_aux <= seen_aux | cfg_wr_aux;
        end
    end

    p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    p_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ad_phase |-> (&cs_n));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_strobe |=> $stable(acc_hit) && $stable(acc_wait) && $stable(acc_rdy_mode));

    p_pinmode_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((~cs_n) & ~pin_cs_mode) == '0);

    p_unwritten_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(seen_ctl && seen_aux) |-> (&cs_n) && !acc_hit);

    p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (&cs_n));

    p_attr_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_hit |-> (acc_wait == 2'b00) && !acc_rdy_mode);

endmodule

bind mcs_decoder mcs_decoder_chk #(.NUM_CS(NUM_CS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr_ctl   (cfg_wr_ctl),
    .cfg_wr_aux   (cfg_wr_aux),
    .pin_cs_mode  (pin_cs_mode),
    .addr_strobe  (addr_strobe),
    .ad_phase     (ad_phase),
    .cs_n         (cs_n),
    .acc_hit      (acc_hit),
    .acc_rdy_mode (acc_rdy_mode),
    .acc_wait     (acc_wait),
    .cfg_err      (cfg_err)
);

// File: tb/tb_mcs_decoder.sv
`timescale 1ns/1ps
module tb_mcs_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_ctl = 1'b0;
    logic        cfg_wr_aux = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        lower_en = 1'b0;
    logic [3:0]  pin_cs_mode = 4'hF;
    logic [19:0] bus_addr = '0;
    logic        addr_strobe = 1'b0;
    logic        ad_phase = 1'b0;
    logic [3:0]  cs_n;
    logic        acc_hit;
    logic        acc_rdy_mode;
    logic [1:0]  acc_wait;
    logic        cfg_err;

    int total = 0;
    int bad = 0;

    // Reference state, built from the writes the bench makes.
    int  m_base = 0;
    int  m_code = 0;
    int  m_rdy = 0;
    int  m_wait = 0;
    bit  m_ctl_seen = 0;
    bit  m_aux_seen = 0;

    always #2 clk = ~clk;

    mcs_decoder dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr_ctl   (cfg_wr_ctl),
        .cfg_wr_aux   (cfg_wr_aux),
        .cfg_wdata    (cfg_wdata),
        .lower_en     (lower_en),
        .pin_cs_mode  (pin_cs_mode),
        .bus_addr     (bus_addr),
        .addr_strobe  (addr_strobe),
        .ad_phase     (ad_phase),
        .cs_n         (cs_n),
        .acc_hit      (acc_hit),
        .acc_rdy_mode (acc_rdy_mode),
        .acc_wait     (acc_wait),
        .cfg_err      (cfg_err)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit ref_err();
        int mask = (1 << m_code) - 1;
        if (!(m_ctl_seen && m_aux_seen)) return 0;
        return (m_code > 6) || ((m_base & mask) != 0) ||
               (m_code == 6 && m_base != 0) || (m_base == 0 && lower_en);
    endfunction

    // Returns {hit, quarter index} per R3/R4/R5.
    function automatic int ref_dec(input int a);
        int mask = (1 << m_code) - 1;
        int hit;
        if (!(m_ctl_seen && m_aux_seen) || ref_err()) return 0;
        hit = ((((a >> 13) ^ m_base) & ~mask & 8'h7F) == 0) ? 1 : 0;
        return (hit << 2) | ((a >> (11 + m_code)) & 3);
    endfunction

    task automatic wr_ctl(input int base, input int rdy, input int wt);
        @(negedge clk);
        cfg_wdata = 16'((base << 9) | (rdy << 2) | wt);
        cfg_wr_ctl = 1'b1;
        @(negedge clk);
        cfg_wr_ctl = 1'b0;
        m_base = base; m_rdy = rdy; m_wait = wt; m_ctl_seen = 1;
    endtask

    task automatic wr_aux(input int code);
        @(negedge clk);
        cfg_wdata = 16'(code);
        cfg_wr_aux = 1'b1;
        @(negedge clk);
        cfg_wr_aux = 1'b0;
        m_code = code; m_aux_seen = 1;
    endtask

    task automatic access(input string req, input int a);
        int r, exp_cs, h;
        @(negedge clk);
        bus_addr = 20'(a);
        addr_strobe = 1'b1;
        @(negedge clk);
        addr_strobe = 1'b0;
        #0.5;
        check({req, " cs_n idle outside phase (R7)"}, int'(cs_n), 4'hF);
        ad_phase = 1'b1;
        #1;
        r = ref_dec(a);
        h = (r >> 2) & 1;
        exp_cs = h ? (~((1 << (r & 3)) & int'(pin_cs_mode)) & 4'hF) : 4'hF;
        check({req, " cs_n"}, int'(cs_n), exp_cs);
        check({req, " acc_hit"}, int'(acc_hit), h);
        check({req, " acc_rdy_mode (R11)"}, int'(acc_rdy_mode), h ? m_rdy : 0);
        check({req, " acc_wait (R11)"}, int'(acc_wait), h ? m_wait : 0);
        check({req, " cfg_err"}, int'(cfg_err), int'(ref_err()));
        ad_phase = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 cs_n", int'(cs_n), 4'hF);
        check("R1 acc_hit", int'(acc_hit), 0);
        check("R1 acc_wait", int'(acc_wait), 0);
        check("R1 acc_rdy_mode", int'(acc_rdy_mode), 0);
        check("R1 cfg_err", int'(cfg_err), 0);

        // R2: control only, then auxiliary.
        wr_ctl(7'h08, 1, 2);
        access("R2 ctl only", 20'h10000);
        check("R2 no hit before aux", int'(acc_hit), 0);
        wr_aux(2);                       // 32 KiB at 10000h, quarters of 8 KiB
        access("R3 R5 q0", 20'h10000);
        access("R5 q1", 20'h12345);
        access("R5 q2", 20'h14000);
        access("R5 q3", 20'h17FFF);
        access("R3 miss above", 20'h18000);
        access("R3 miss below", 20'h0FFFF);
        check("R3 miss reports no hit", int'(acc_hit), 0);

        // R8: misaligned base.
        wr_ctl(7'h0A, 0, 1);
        check("R8 misaligned cfg_err", int'(cfg_err), 1);
        access("R8 misaligned", 20'h14000);
        // R8: 512 KiB only at zero.
        wr_ctl(7'h40, 0, 3);
        wr_aux(6);
        check("R8 full size nonzero base", int'(cfg_err), 1);
        access("R8 full size nonzero", 20'h80000);
        wr_ctl(7'h00, 1, 3);
        access("R8 full size at zero q3", 20'h7FFFF);
        access("R8 full size at zero q1", 20'h20000);
        // R9: base zero while lower region on.
        lower_en = 1'b1;
        #1;
        check("R9 overlap cfg_err", int'(cfg_err), 1);
        access("R9 overlap", 20'h00100);
        lower_en = 1'b0;
        // R4: invalid code and the smallest window.
        wr_ctl(7'h55, 0, 1);
        wr_aux(7);
        check("R4 code 7 cfg_err", int'(cfg_err), 1);
        access("R4 code 7", 20'hAA000);
        wr_aux(0);                       // 8 KiB at AA000h
        access("R4 8K q0", 20'hAA000);
        access("R4 8K q3", 20'hABFFF);
        access("R4 8K miss", 20'hAC000);
        // R10: pin in I/O mode.
        pin_cs_mode = 4'b0111;
        access("R10 gated pin", 20'hABFFF);
        check("R10 hit still reported", int'(acc_hit), 1);
        pin_cs_mode = 4'hF;

        // Random configurations and accesses.
        for (int k = 0; k < 120; k++) begin
            int code, base, mask, a;
            code = int'($urandom_range(0, 6));
            mask = (1 << code) - 1;
            base = int'($urandom & 32'h7F) & ~mask;
            if (code == 6) base = 0;
            lower_en = (base != 0) ? 1'($urandom) : 1'b0;
            pin_cs_mode = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'hF;
            wr_ctl(base, int'($urandom_range(0, 1)), int'($urandom_range(0, 3)));
            wr_aux(code);
            for (int j = 0; j < 6; j++) begin
                if (j < 4)
                    a = (base << 13) + int'($urandom_range(0, (8192 << code) - 1));
                else
                    a = int'($urandom & 32'hFFFFF);
                access("R3 R5 R10 R11 random", a & 20'hFFFFF);
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule